// File: doc/BRIEF.md
# Switch-Level Transistor Device Evaluator

This block computes what a single transistor switch presents at its output node. It takes a data input as a four-state value with a strength, one or two gate controls, and a device-type code. It returns a four-state value with a strength, plus an ambiguity flag. The flag marks results that can only be narrowed to "0 or floating" or to "1 or floating". A design that models transistor networks in hardware would instantiate one evaluator per switch. It would then pass the outputs to a separate net-resolution stage, which this block does not contain.

The device code picks an n-channel switch, a p-channel switch or a complementary pair, each in plain or resistive form. Passing through a plain switch only demotes a supply-strength input to strong. Passing through a resistive switch lowers the strength more steeply, following a fixed table. The result is registered, so every output reflects the inputs sampled one clock edge earlier.

Top module: `swl_switch_eval`

## Requirements
- R1: Value code is 0→logic 0, 1→logic 1, 2→x, 3→z. Strength code runs from 7 (supply) through 6 strong, 5 pull, 4 large, 3 weak, 2 medium and 1 small down to 0 (high impedance). Device code bit 2 selects the resistive form. Bits 1:0 select 0 n-channel, 1 p-channel, 2 complementary.
- R2: An n-channel device uses `ctl_n` only. Control 0 yields z. Control 1 passes the input value.
- R3: A p-channel device uses `ctl_p` only. Control 1 yields z. Control 0 passes the input value.
- R4: When the deciding control is x or z, the outputs depend on the input value. Input 0 gives value 0 with `out_amb`=1 (L). Input 1 gives value 1 with `out_amb`=1 (H). Input x gives x with `out_amb`=0. Input z gives z.
- R5: A complementary device conducts if either half conducts. It is off only when `ctl_n`=0 and `ctl_p`=1. Any other combination with no conducting half gives the R4 result.
- R6: A plain device maps strength 7 to 6 and passes every other strength unchanged.
- R7: A resistive device maps strength 7→5, 6→5, 5→3, 4→2, 3→2, 2→1, 1→1, 0→0.
- R8: A z output always carries strength 0. An input with value z or with strength 0 produces a z output.
- R9: The output strength never exceeds the input strength and is never 7.
- R10: Outputs are registered with one cycle of latency. Asynchronous active-low reset sets value z, strength 0 and `out_amb` 0.
- R11: A device code with bits 1:0 equal to 3 is no device and always yields z.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dev_sel | input | 3 | Device type code |
| din_val | input | 2 | Data input value |
| din_str | input | 3 | Data input strength |
| ctl_n | input | 2 | Four-state control of the n-channel gate |
| ctl_p | input | 2 | Four-state control of the p-channel gate |
| out_val | output | 2 | Output value |
| out_str | output | 3 | Output strength |
| out_amb | output | 1 | Output is L (value 0) or H (value 1) |

## Verification
The bench builds the block with the package defaults: a 3-bit strength field and a 2-bit value field. At these widths, every strength level can be swept through both the plain and the resistive reduction path. The vector table covers each control state of every device kind, including the complementary combinations where one half is unknown and the other is off or on. It also covers the two unused device codes, so the no-device path is checked as well.

// File: rtl/swl_pkg.sv
package swl_pkg;
    localparam int STR_W = 3;
    localparam int VAL_W = 2;
    localparam int DEV_W = 3;
    localparam logic [STR_W-1:0] STR_SUPPLY = '1;
    localparam logic [STR_W-1:0] STR_STRONG = STR_SUPPLY - 1'b1;
    localparam logic [STR_W-1:0] STR_HIGHZ  = '0;

    typedef logic [STR_W-1:0] str_t;

    typedef enum logic [VAL_W-1:0] {
        LV_0 = 2'd0,
        LV_1 = 2'd1,
        LV_X = 2'd2,
        LV_Z = 2'd3
    } lval_e;

    typedef enum logic [1:0] {
        COND_OFF = 2'd0,
        COND_ON  = 2'd1,
        COND_UNK = 2'd2
    } cond_e;

    typedef enum logic [1:0] {
        KIND_N    = 2'd0,
        KIND_P    = 2'd1,
        KIND_C    = 2'd2,
        KIND_NONE = 2'd3
    } kind_e;

    typedef struct packed {
        lval_e val;
        str_t  str;
        logic  amb;
    } drv_t;
endpackage

// File: rtl/swl_gate_ctl.sv
module swl_gate_ctl
    import swl_pkg::*;
#(
    parameter logic ON_LEVEL = 1'b1
) (
    input  logic [VAL_W-1:0] ctl,
    output cond_e            cond
);
    always_comb begin
        case (ctl)
            2'd0:    cond = (ON_LEVEL == 1'b0) ? COND_ON : COND_OFF;
            2'd1:    cond = (ON_LEVEL == 1'b1) ? COND_ON : COND_OFF;
            default: cond = COND_UNK;
        endcase
    end
endmodule

// File: rtl/swl_str_reduce.sv
module swl_str_reduce
    import swl_pkg::*;
(
    input  str_t str_in,
    input  logic resistive,
    output str_t str_out
);
    str_t plain_s;
    str_t resist_s;

    always_comb begin
        plain_s = (str_in == STR_SUPPLY) ? STR_STRONG : str_in;
        case (str_in)
            3'd7:    resist_s = 3'd5;
            3'd6:    resist_s = 3'd5;
            3'd5:    resist_s = 3'd3;
            3'd4:    resist_s = 3'd2;
            3'd3:    resist_s = 3'd2;
            3'd2:    resist_s = 3'd1;
            3'd1:    resist_s = 3'd1;
            default: resist_s = 3'd0;
        endcase
        str_out = resistive ? resist_s : plain_s;
    end

    always_comb begin
        a_no_gain_r9: assert (str_out <= str_in);
    end
endmodule

// File: rtl/swl_switch_eval.sv
module swl_switch_eval
    import swl_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DEV_W-1:0] dev_sel,
    input  logic [VAL_W-1:0] din_val,
    input  logic [STR_W-1:0] din_str,
    input  logic [VAL_W-1:0] ctl_n,
    input  logic [VAL_W-1:0] ctl_p,
    output logic [VAL_W-1:0] out_val,
    output logic [STR_W-1:0] out_str,
    output logic             out_amb
);
    cond_e n_cond;
    cond_e p_cond;
    cond_e dev_cond;
    kind_e kind;
    str_t  red_str;
    drv_t  out_d;
    drv_t  out_q;

    swl_gate_ctl #(.ON_LEVEL(1'b1)) u_n_gate (.ctl(ctl_n), .cond(n_cond));
    swl_gate_ctl #(.ON_LEVEL(1'b0)) u_p_gate (.ctl(ctl_p), .cond(p_cond));

    swl_str_reduce u_reduce (
        .str_in   (din_str),
        .resistive(dev_sel[2]),
        .str_out  (red_str)
    );

    assign kind = kind_e'(dev_sel[1:0]);

    always_comb begin
        case (kind)
            KIND_N:  dev_cond = n_cond;
            KIND_P:  dev_cond = p_cond;
            KIND_C: begin
                if (n_cond == COND_ON || p_cond == COND_ON)
                    dev_cond = COND_ON;
                else if (n_cond == COND_OFF && p_cond == COND_OFF)
                    dev_cond = COND_OFF;
                else
                    dev_cond = COND_UNK;
            end
            default: dev_cond = COND_OFF;
        endcase
    end

    always_comb begin
        out_d.val = LV_Z;
        out_d.str = STR_HIGHZ;
        out_d.amb = 1'b0;
        if (din_val != LV_Z && din_str != STR_HIGHZ) begin
            case (dev_cond)
                COND_ON: begin
                    out_d.val = lval_e'(din_val);
                    out_d.str = red_str;
                end
                COND_UNK: begin
                    out_d.val = lval_e'(din_val);
                    out_d.str = red_str;
                    out_d.amb = (din_val == LV_0) || (din_val == LV_1);
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            out_q <= '{val: LV_Z, str: STR_HIGHZ, amb: 1'b0};
        end else begin
            out_q <= out_d;
        end
    end

    assign out_val = out_q.val;
    assign out_str = out_q.str;
    assign out_amb = out_q.amb;

    p_z_weak_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_val == LV_Z) |-> (out_str == STR_HIGHZ));

    p_no_supply_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_str != STR_SUPPLY);

    p_amb_binary_r4: assert property (@(posedge clk) disable iff (!rst_n)
        out_amb |-> (out_val == LV_0 || out_val == LV_1));

    p_n_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel[1:0] == KIND_N && ctl_n == 2'd0) |=> (out_val == LV_Z));

    p_p_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel[1:0] == KIND_P && ctl_p == 2'd1) |=> (out_val == LV_Z));

    p_none_z_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_sel[1:0] == KIND_NONE) |=> (out_val == LV_Z));

    p_ztrack_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (din_val == LV_Z || din_str == STR_HIGHZ) |=> (out_str == STR_HIGHZ));
endmodule

// File: tb/swl_switch_eval_bench.sv
module swl_switch_eval_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 23;
    localparam int WATCHDOG = 5000;

    typedef struct packed {
        logic [2:0] dev;
        logic [1:0] dv;
        logic [2:0] ds;
        logic [1:0] cn;
        logic [1:0] cp;
        logic [1:0] ev;
        logic [2:0] es;
        logic       ea;
    } vec_t;

    // values: 0,1,2=x,3=z ; dev: 0 n,1 p,2 c,3 none, +4 resistive
    localparam vec_t VEC [NVEC] = '{
        '{3'd0, 2'd1, 3'd5, 2'd1, 2'd1, 2'd1, 3'd5, 1'b0}, // R2 on
        '{3'd0, 2'd0, 3'd7, 2'd1, 2'd0, 2'd0, 3'd6, 1'b0}, // R2 R6
        '{3'd0, 2'd1, 3'd6, 2'd0, 2'd0, 2'd3, 3'd0, 1'b0}, // R2 off
        '{3'd0, 2'd0, 3'd6, 2'd2, 2'd1, 2'd0, 3'd6, 1'b1}, // R4 L
        '{3'd0, 2'd1, 3'd3, 2'd3, 2'd1, 2'd1, 3'd3, 1'b1}, // R4 H
        '{3'd0, 2'd2, 3'd6, 2'd2, 2'd1, 2'd2, 3'd6, 1'b0}, // R4 x
        '{3'd0, 2'd3, 3'd6, 2'd1, 2'd1, 2'd3, 3'd0, 1'b0}, // R8 z in
        '{3'd1, 2'd1, 3'd6, 2'd1, 2'd0, 2'd1, 3'd6, 1'b0}, // R3 on
        '{3'd1, 2'd0, 3'd6, 2'd0, 2'd1, 2'd3, 3'd0, 1'b0}, // R3 off
        '{3'd1, 2'd1, 3'd7, 2'd1, 2'd2, 2'd1, 3'd6, 1'b1}, // R4 p H
        '{3'd2, 2'd0, 3'd6, 2'd0, 2'd1, 2'd3, 3'd0, 1'b0}, // R5 off
        '{3'd2, 2'd1, 3'd7, 2'd1, 2'd1, 2'd1, 3'd6, 1'b0}, // R5 n on
        '{3'd2, 2'd0, 3'd5, 2'd0, 2'd0, 2'd0, 3'd5, 1'b0}, // R5 p on
        '{3'd2, 2'd1, 3'd5, 2'd2, 2'd1, 2'd1, 3'd5, 1'b1}, // R5 unk
        '{3'd2, 2'd0, 3'd5, 2'd2, 2'd0, 2'd0, 3'd5, 1'b0}, // R5 unk+on
        '{3'd4, 2'd1, 3'd7, 2'd1, 2'd1, 2'd1, 3'd5, 1'b0}, // R7 rn
        '{3'd5, 2'd0, 3'd5, 2'd1, 2'd0, 2'd0, 3'd3, 1'b0}, // R7 rp
        '{3'd6, 2'd1, 3'd4, 2'd1, 2'd1, 2'd1, 3'd2, 1'b0}, // R7 rc
        '{3'd4, 2'd0, 3'd1, 2'd2, 2'd1, 2'd0, 3'd1, 1'b1}, // R7 R4
        '{3'd0, 2'd1, 3'd0, 2'd1, 2'd1, 2'd3, 3'd0, 1'b0}, // R8 str0
        '{3'd3, 2'd1, 3'd6, 2'd1, 2'd0, 2'd3, 3'd0, 1'b0}, // R11
        '{3'd7, 2'd1, 3'd6, 2'd1, 2'd0, 2'd3, 3'd0, 1'b0}, // R11 res
        '{3'd0, 2'd2, 3'd7, 2'd1, 2'd1, 2'd2, 3'd6, 1'b0}  // R1 x pass
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dev_sel = '0;
    logic [1:0] din_val = '0;
    logic [2:0] din_str = '0;
    logic [1:0] ctl_n = '0;
    logic [1:0] ctl_p = '0;
    logic [1:0] out_val;
    logic [2:0] out_str;
    logic       out_amb;

    int n_checks = 0;
    int n_fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    swl_switch_eval u_swl_switch_eval (
        .clk(clk), .rst_n(rst_n), .dev_sel(dev_sel), .din_val(din_val),
        .din_str(din_str), .ctl_n(ctl_n), .ctl_p(ctl_p),
        .out_val(out_val), .out_str(out_str), .out_amb(out_amb)
    );

    function automatic logic [2:0] exp_str(input logic [2:0] s, input logic res);
        logic [2:0] m [8];
        if (!res) return (s == 3'd7) ? 3'd6 : s;
        m = '{3'd0, 3'd1, 3'd1, 3'd2, 3'd2, 3'd3, 3'd5, 3'd5};
        return m[s];
    endfunction

    task automatic check(input string req, input logic [1:0] ev,
                         input logic [2:0] es, input logic ea);
        n_checks++;
        if (out_val !== ev || out_str !== es || out_amb !== ea) begin
            n_fails++;
            $display("FAIL %s: got val=%0d str=%0d amb=%0d, expected val=%0d str=%0d amb=%0d",
                     req, out_val, out_str, out_amb, ev, es, ea);
        end
    endtask

    task automatic drive(input logic [2:0] d, input logic [1:0] v, input logic [2:0] s,
                         input logic [1:0] n, input logic [1:0] p);
        @(negedge clk);
        dev_sel = d; din_val = v; din_str = s; ctl_n = n; ctl_p = p;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R10 reset", 2'd3, 3'd0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i].dev, VEC[i].dv, VEC[i].ds, VEC[i].cn, VEC[i].cp);
            check($sformatf("R1..vec%0d", i), VEC[i].ev, VEC[i].es, VEC[i].ea);
        end

        for (int s = 0; s < 8; s++) begin
            drive(3'd0, 2'd1, 3'(s), 2'd1, 2'd1);
            check("R6 plain sweep", (s == 0) ? 2'd3 : 2'd1, exp_str(3'(s), 1'b0), 1'b0);
            drive(3'd4, 2'd0, 3'(s), 2'd1, 2'd1);
            check("R7 resistive sweep", (s == 0) ? 2'd3 : 2'd0, exp_str(3'(s), 1'b1), 1'b0);
        end

        // R10 latency: output still holds previous result right after a new input
        drive(3'd0, 2'd1, 3'd6, 2'd1, 2'd0);
        @(negedge clk);
        dev_sel = 3'd0; ctl_n = 2'd0;
        #1;
        check("R10 latency hold", 2'd1, 3'd6, 1'b0);
        @(negedge clk);
        check("R10 latency update", 2'd3, 3'd0, 1'b0);

        // R10 async reset mid-run
        drive(3'd0, 2'd0, 3'd7, 2'd1, 2'd0);
        check("R9 supply demoted", 2'd0, 3'd6, 1'b0);
        #2 rst_n = 1'b0;
        #1 check("R10 async reset", 2'd3, 3'd0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(3'd1, 2'd1, 3'd6, 2'd2, 2'd1);
        check("R3 ignores ctl_n", 2'd3, 3'd0, 1'b0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: got hang, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule